// File: doc/BRIEF.md
# SPI Master Byte Exchange Engine

This block is a register-programmed SPI master. Software loads outgoing bytes into a transmit FIFO and sets two 24-bit counters. It then writes the start bit in the transfer register. The engine clocks out the requested number of bytes, most significant bit first. It captures one incoming byte per outgoing byte into a receive FIFO. Software reads the fill level of that FIFO and then drains it through the receive data register.

The serial clock rate comes from outside the block. Each pulse on `sck_tick` marks one half period of SCK. The engine moves only on those pulses. Clock polarity and phase are set by two mode bits. Four chip-select lines are provided. The selected line either follows the engine's busy state or is held by a software level bit. The active level of the lines is programmable.

The register bus is a single-cycle strobe interface. Read data is combinational from the address. A read of the receive data register removes that byte from the FIFO at the clock edge that ends the read.

Top module: `spi_xchg_top`

## Requirements
- R1: After synchronous reset, every register reads zero and both FIFOs are empty. `spi_sck`, `spi_mosi` and all `spi_cs` lines are 0.
- R2: Register word addresses decode from `reg_addr[4:2]` as follows:
    - 0 is global control.
    - 1 is transfer control.
    - 2 is FIFO control.
    - 3 is FIFO status.
    - 4 is the burst count.
    - 5 is the transmit count.
    - 6 is the TX data write port, which takes bits 7:0.
    - 7 is the RX data read port.

  With enable (global bit 0) set, writing 1 to transfer bit 31 clocks out burst-count bytes, MSB first. Each byte received on `spi_miso` is pushed into the RX FIFO. FIFO status bits 7:0 give the RX fill count.
- R3: Transfer bit 1 (CPOL) sets the idle level of SCK. With transfer bit 0 (CPHA) at 0, MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. With CPHA at 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R4: Transfer bit 31 reads 1 while an exchange runs. It clears by itself after the last bit of the last byte has been sampled.
- R5: The first transmit-count bytes of a burst are taken from the TX FIFO. A byte beyond the transmit count, or a byte requested while the TX FIFO is empty, goes out as 0x00.
- R6: In automatic mode (transfer bit 6 = 0), the line indexed by transfer bits 5:4 is asserted only while an exchange runs. All other lines stay deasserted. Transfer bit 2 = 1 makes asserted mean 0, and bit 2 = 0 makes asserted mean 1.
- R7: In manual mode (transfer bit 6 = 1), the selected line is asserted when transfer bit 7 is 0 and deasserted when bit 7 is 1.
- R8: Writing 1 to FIFO control bit 15 empties the RX FIFO. Writing 1 to bit 31 empties the TX FIFO. Both bits read back as 0 again two cycles after the write.
- R9: Writing 1 to global bit 31 aborts a running exchange, returns SCK to idle and empties both FIFOs. The bit clears itself.
- R10: A start request while enable is 0 is ignored. No SCK edge occurs and the busy bit stays 0.
- R11: While the pause bit (global bit 7) is 1, a running exchange holds SCK and all shifting. Clearing the bit lets the exchange resume and finish with correct data.
- R12: A start with a burst count of 0 produces no SCK edge, and the busy bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at word 7) |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| sck_tick | input | 1 | Half-period strobe for SCK |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
The bench models a slave that drives MISO and records MOSI on the sampling edges for the current CPHA. Random exchanges draw the following at random:
- mode,
- burst length,
- transmit count,
- number of preloaded bytes.

These separate bit-order and phase errors from zero-fill errors, because short transmit counts and empty-FIFO underflow each produce their own 0x00 bytes. Directed cases cover the following:
- a zero-length burst,
- a start while disabled,
- a pause held in mid-byte,
- an abort in mid-byte,
- both FIFO resets,
- manual chip select under both polarities.

Each directed case is told apart by counting SCK edges or by reading the FIFO level at the ports.

// File: rtl/spi_xchg_pkg.sv
// Shared register indices, field positions and widths for the SPI exchange block.
package spi_xchg_pkg;

    // Word index within the register window (reg_addr[4:2]).
    typedef enum logic [2:0] {
        RG_GLOBAL   = 3'd0,
        RG_XFER     = 3'd1,
        RG_FIFOCTL  = 3'd2,
        RG_FIFOSTAT = 3'd3,
        RG_BURST    = 3'd4,
        RG_XMIT     = 3'd5,
        RG_TXDATA   = 3'd6,
        RG_RXDATA   = 3'd7
    } reg_idx_e;

    localparam int CNT_W = 24;
    localparam int SEL_W = 2;

    // Global control bits
    localparam int GB_EN     = 0;
    localparam int GB_MASTER = 1;
    localparam int GB_PAUSE  = 7;
    localparam int GB_SRST   = 31;

    // Transfer control bits
    localparam int XB_CPHA   = 0;
    localparam int XB_CPOL   = 1;
    localparam int XB_ACTLOW = 2;
    localparam int XB_SEL_LO = 4;
    localparam int XB_MANUAL = 6;
    localparam int XB_LEVEL  = 7;
    localparam int XB_START  = 31;

    // FIFO control bits
    localparam int FB_RXRST = 15;
    localparam int FB_TXRST = 31;

    // Transfer configuration held by the register block.
    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             act_low;
        logic [SEL_W-1:0] sel;
        logic             manual;
        logic             level;
    } xfer_cfg_t;

endpackage

// File: rtl/spi_byte_fifo.sv
// Synchronous FIFO used for both directions.
// Assumes: push while full and pop while empty are dropped; flush wins over
// push and pop in the same cycle; pop_data reads 0 when empty.
module spi_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = empty ? '0 : mem[rptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and level bookkeeping with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R8

endmodule

// File: rtl/spi_shift_engine.sv
// Bit engine: clocks out burst_cnt bytes and captures as many bytes in.
// Assumes: one sck_tick equals one SCK half period; mode bits stay
// constant during an exchange; abort returns to idle at once.
module spi_shift_engine #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [CNT_W-1:0] burst_cnt,
    input  logic [CNT_W-1:0] xmit_cnt,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             tick,
    input  logic             pause,
    input  logic [7:0]       tx_data,
    input  logic             tx_empty,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);

    logic [3:0]       edge_q;
    logic             sck_ph;
    logic [7:0]       tsh, rsh;
    logic             mosi_q;
    logic [CNT_W-1:0] bytes_left, tx_left, tx_left_nxt;
    logic             step, last_edge, next_byte, start_ok, load_now, tx_avail;
    logic             lead, samp_edge, shift_edge;
    logic [7:0]       ld_byte, ld_tsh;
    logic             ld_mosi;

    assign step       = busy && tick && !pause;
    assign last_edge  = step && (edge_q == 4'd15);
    assign next_byte  = last_edge && (bytes_left != CNT_W'(1));
    assign start_ok   = start && !busy && (burst_cnt != '0);
    assign load_now   = start_ok || next_byte;
    assign tx_avail   = start_ok ? (xmit_cnt != '0) : (tx_left != '0);
    assign tx_pop     = load_now && tx_avail && !tx_empty;
    assign ld_byte    = (tx_avail && !tx_empty) ? tx_data : 8'h00;
    assign tx_left_nxt = (start_ok ? xmit_cnt : tx_left) - CNT_W'(tx_avail);
    assign ld_tsh     = cpha ? ld_byte : {ld_byte[6:0], 1'b0};
    assign ld_mosi    = cpha ? mosi_q : ld_byte[7];
    assign lead       = ~edge_q[0];
    assign samp_edge  = cpha ? ~lead : lead;
    assign shift_edge = ~samp_edge;
    assign rx_push    = last_edge;
    assign rx_data    = cpha ? {rsh[6:0], miso} : rsh;
    assign sck        = cpol ^ sck_ph;
    assign mosi       = mosi_q;

    // Exchange sequencing: start, per-edge shift/sample, byte reload, finish.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy       <= 1'b0;
            sck_ph     <= 1'b0;
            edge_q     <= '0;
            tsh        <= '0;
            rsh        <= '0;
            mosi_q     <= 1'b0;
            bytes_left <= '0;
            tx_left    <= '0;
        end else if (start_ok) begin
            busy       <= 1'b1;
            sck_ph     <= 1'b0;
            edge_q     <= '0;
            bytes_left <= burst_cnt;
            tx_left    <= tx_left_nxt;
            tsh        <= ld_tsh;
            mosi_q     <= ld_mosi;
        end else if (step) begin
            sck_ph <= ~sck_ph;
            edge_q <= edge_q + 4'd1;
            if (samp_edge) rsh <= {rsh[6:0], miso};
            if (edge_q == 4'd15) begin
                if (bytes_left == CNT_W'(1)) begin
                    busy       <= 1'b0;
                    bytes_left <= '0;
                end else begin
                    bytes_left <= bytes_left - CNT_W'(1);
                    tx_left    <= tx_left_nxt;
                    tsh        <= ld_tsh;
                    mosi_q     <= ld_mosi;
                end
            end else if (shift_edge) begin
                mosi_q <= tsh[7];
                tsh    <= {tsh[6:0], 1'b0};
            end
        end
    end

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol)); // R3
    AST_SCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pause && !abort) |=> ((sck == $past(sck)) || (cpol != $past(cpol)))); // R11
    AST_ZERO_BURST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && burst_cnt == '0) |=> !busy); // R12

endmodule

// File: rtl/spi_cs_ctrl.sv
// Chip-select drivers: one line per index, automatic or software level.
// Assumes: sel picks exactly one line; lines not selected stay deasserted.
module spi_cs_ctrl #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             manual,
    input  logic             level,
    input  logic             act_low,
    input  logic             busy,
    output logic [NUM_CS-1:0] cs
);

    logic want;
    assign want = manual ? !level : busy;

    // One driver per line; polarity applied at the pin.
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_line
        logic hit;
        assign hit    = want && (sel == SEL_W'(gi));
        assign cs[gi] = act_low ? !hit : hit;
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs ^ {NUM_CS{act_low}})); // R6

endmodule

// File: rtl/spi_xchg_top.sv
// SPI master exchange block: register file, TX/RX FIFOs, shift engine and
// chip-select drivers. Assumes a single-cycle strobe register bus with
// combinational read data; a read of the RX data word pops that byte.
module spi_xchg_top #(
    parameter int FIFO_DEPTH = 64,
    parameter int NUM_CS     = 4,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sck_tick,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    import spi_xchg_pkg::*;

    reg_idx_e         ridx;
    logic             g_en, g_master, g_pause, srst_q;
    xfer_cfg_t        cfg;
    logic             rxrst_q, txrst_q;
    logic [CNT_W-1:0] burst_q, xmit_q;
    logic             start_req, start_go;
    logic             eng_busy, tx_pop, rx_push;
    logic [7:0]       tx_dout, rx_din, rx_dout;
    logic [CW-1:0]    tx_count, rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             unused_bits;

    assign ridx        = reg_idx_e'(reg_addr[4:2]);
    assign start_req   = reg_wr && (ridx == RG_XFER) && reg_wdata[XB_START];
    assign start_go    = start_req && g_en && !srst_q;
    assign unused_bits = ^{reg_wdata[30:24], reg_addr[1:0], tx_full, rx_full, rx_empty};

    // Register writes; reset-type bits are pulses that clear the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_en     <= 1'b0;
            g_master <= 1'b0;
            g_pause  <= 1'b0;
            srst_q   <= 1'b0;
            cfg      <= '0;
            rxrst_q  <= 1'b0;
            txrst_q  <= 1'b0;
            burst_q  <= '0;
            xmit_q   <= '0;
        end else begin
            srst_q  <= 1'b0;
            rxrst_q <= 1'b0;
            txrst_q <= 1'b0;
            if (reg_wr) begin
                unique case (ridx)
                    RG_GLOBAL: begin
                        g_en     <= reg_wdata[GB_EN];
                        g_master <= reg_wdata[GB_MASTER];
                        g_pause  <= reg_wdata[GB_PAUSE];
                        srst_q   <= reg_wdata[GB_SRST];
                    end
                    RG_XFER: begin
                        cfg.cpha    <= reg_wdata[XB_CPHA];
                        cfg.cpol    <= reg_wdata[XB_CPOL];
                        cfg.act_low <= reg_wdata[XB_ACTLOW];
                        cfg.sel     <= reg_wdata[XB_SEL_LO +: SEL_W];
                        cfg.manual  <= reg_wdata[XB_MANUAL];
                        cfg.level   <= reg_wdata[XB_LEVEL];
                    end
                    RG_FIFOCTL: begin
                        rxrst_q <= reg_wdata[FB_RXRST];
                        txrst_q <= reg_wdata[FB_TXRST];
                    end
                    RG_BURST: burst_q <= reg_wdata[CNT_W-1:0];
                    RG_XMIT:  xmit_q  <= reg_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (ridx)
            RG_GLOBAL: begin
                reg_rdata[GB_EN]     = g_en;
                reg_rdata[GB_MASTER] = g_master;
                reg_rdata[GB_PAUSE]  = g_pause;
                reg_rdata[GB_SRST]   = srst_q;
            end
            RG_XFER: begin
                reg_rdata[XB_CPHA]              = cfg.cpha;
                reg_rdata[XB_CPOL]              = cfg.cpol;
                reg_rdata[XB_ACTLOW]            = cfg.act_low;
                reg_rdata[XB_SEL_LO +: SEL_W]   = cfg.sel;
                reg_rdata[XB_MANUAL]            = cfg.manual;
                reg_rdata[XB_LEVEL]             = cfg.level;
                reg_rdata[XB_START]             = eng_busy;
            end
            RG_FIFOCTL: begin
                reg_rdata[FB_RXRST] = rxrst_q;
                reg_rdata[FB_TXRST] = txrst_q;
            end
            RG_FIFOSTAT: reg_rdata[7:0] = 8'(rx_count);
            RG_BURST:    reg_rdata[CNT_W-1:0] = burst_q;
            RG_XMIT:     reg_rdata[CNT_W-1:0] = xmit_q;
            RG_RXDATA:   reg_rdata[7:0] = rx_dout;
            default:     reg_rdata = '0;
        endcase
    end

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(txrst_q || srst_q),
        .push(reg_wr && ridx == RG_TXDATA), .push_data(reg_wdata[7:0]),
        .pop(tx_pop), .pop_data(tx_dout),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(rxrst_q || srst_q),
        .push(rx_push), .push_data(rx_din),
        .pop(reg_rd && ridx == RG_RXDATA), .pop_data(rx_dout),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.CNT_W(CNT_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .abort(srst_q), .start(start_go),
        .burst_cnt(burst_q), .xmit_cnt(xmit_q),
        .cpol(cfg.cpol), .cpha(cfg.cpha), .tick(sck_tick), .pause(g_pause),
        .tx_data(tx_dout), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_din), .busy(eng_busy),
        .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
    );

    spi_cs_ctrl #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) cs_i (
        .clk(clk), .rst_n(rst_n), .sel(cfg.sel), .manual(cfg.manual),
        .level(cfg.level), .act_low(cfg.act_low), .busy(eng_busy), .cs(spi_cs)
    );

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !g_en && !eng_busy) |=> !eng_busy); // R10
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (!eng_busy && rx_count == '0 && tx_count == '0)); // R9

endmodule

// File: tb/spi_xchg_top_tb_top.sv
`timescale 1ns/100ps
module spi_xchg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck_tick = 1'b0;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_cs;

    int n_checks = 0, n_errors = 0;
    bit finished = 0;

    localparam logic [4:0] A_GLB = 5'h00, A_XFR = 5'h04, A_FCT = 5'h08,
        A_FST = 5'h0C, A_BUR = 5'h10, A_XMT = 5'h14, A_TXD = 5'h18, A_RXD = 5'h1C;

    always #2 clk = ~clk;  // 250 MHz

    spi_xchg_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_tick(sck_tick), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    // SCK half-period strobe every third clock.
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            sck_tick = 1'b1;
            @(negedge clk);
            sck_tick = 1'b0;
        end
    end

    // Slave model: edge counter, MISO stream and MOSI capture.
    logic [7:0] sl [64];
    logic [7:0] mo [64];
    logic [7:0] txb [64];
    int  ecnt = 0, base = 0;
    bit  b_cpha = 0;
    logic miso_bit;

    always_comb begin
        int rel, bi;
        rel = ecnt - base;
        if (b_cpha) bi = (rel <= 0) ? 0 : (rel - 1) / 2;
        else        bi = rel / 2;
        miso_bit = (bi >= 0 && bi < 512) ? sl[bi / 8][7 - (bi % 8)] : 1'b0;
    end
    assign spi_miso = miso_bit;

    always @(spi_sck) begin
        int rel, bi;
        rel = ecnt - base;
        if ((rel % 2 == 0) != b_cpha) begin
            bi = b_cpha ? (rel - 1) / 2 : rel / 2;
            if (bi >= 0 && bi < 512) mo[bi / 8][7 - (bi % 8)] = spi_mosi;
        end
        ecnt = ecnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] mk_xfr(bit st, bit cpha, bit cpol, bit al,
                                           logic [1:0] sel, bit man, bit lvl);
        return {st, 23'd0, lvl, man, sel, 1'b0, al, cpol, cpha};
    endfunction

    function automatic logic [3:0] exp_cs(logic [1:0] sel, bit asserted, bit al);
        logic [3:0] v = asserted ? (4'b0001 << sel) : 4'b0000;
        return al ? ~v : v;
    endfunction

    function automatic logic [7:0] exp_mosi(int i, int xm, int nl);
        return (i < xm && i < nl) ? txb[i] : 8'h00;
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 4000; k++) begin
            rd(A_XFR, v);
            if (!v[31]) return;
        end
        check("R4", 32'd1, 32'd0, "busy never cleared");
    endtask

    bit cur_cpha, cur_cpol;
    logic [1:0] cur_sel;

    task automatic xg_setup(bit cpha, bit cpol, logic [1:0] sel, int nb, int xm, int nl);
        wr(A_XFR, mk_xfr(0, cpha, cpol, 1, sel, 0, 0));
        repeat (3) @(negedge clk);
        cur_cpha = cpha; cur_cpol = cpol; cur_sel = sel;
        b_cpha = cpha;
        base = ecnt;
        for (int i = 0; i < 64; i++) sl[i] = 8'($urandom);
        for (int i = 0; i < nl; i++) begin
            txb[i] = 8'($urandom);
            wr(A_TXD, {24'd0, txb[i]});
        end
        wr(A_BUR, nb);
        wr(A_XMT, xm);
    endtask

    task automatic xg_start();
        wr(A_XFR, mk_xfr(1, cur_cpha, cur_cpol, 1, cur_sel, 0, 0));
    endtask

    task automatic xg_finish(string req, int nb, int xm, int nl);
        logic [31:0] v;
        wait_idle();
        for (int i = 0; i < nb; i++) check(req, {24'd0, mo[i]}, {24'd0, exp_mosi(i, xm, nl)}, "MOSI byte");
        rd(A_FST, v);
        check("R2", v, nb, "RX fill count");
        for (int i = 0; i < nb; i++) begin
            rd(A_RXD, v);
            check("R2", v, {24'd0, sl[i]}, "RX byte");
        end
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int e1;
        void'($urandom(32'h5A17C3));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_GLB, v); check("R1", v, 0, "global reg");
        rd(A_XFR, v); check("R1", v, 0, "transfer reg");
        rd(A_FST, v); check("R1", v, 0, "fifo status");
        rd(A_BUR, v); check("R1", v, 0, "burst reg");
        check("R1", {28'd0, spi_cs}, 0, "cs lines");
        check("R1", {30'd0, spi_sck, spi_mosi}, 0, "sck/mosi");

        // R10 start while disabled
        wr(A_BUR, 2); wr(A_XMT, 2);
        base = ecnt;
        wr(A_XFR, mk_xfr(1, 0, 0, 1, 0, 0, 0));
        repeat (40) @(negedge clk);
        check("R10", ecnt - base, 0, "SCK edges while disabled");
        rd(A_XFR, v); check("R10", v[31], 0, "busy while disabled");

        wr(A_GLB, 32'h1);

        // R3 idle level follows CPOL
        wr(A_XFR, mk_xfr(0, 0, 1, 1, 0, 0, 0));
        repeat (2) @(negedge clk);
        check("R3", spi_sck, 1, "idle SCK with CPOL=1");

        // Directed exchange, mode 0, with busy and auto CS checks (R2 R4 R6)
        xg_setup(0, 0, 2'd2, 3, 3, 3);
        xg_start();
        repeat (5) @(negedge clk);
        check("R6", spi_cs, exp_cs(2, 1, 1), "auto CS during exchange");
        rd(A_XFR, v); check("R4", v[31], 1, "busy during exchange");
        xg_finish("R2", 3, 3, 3);
        check("R6", spi_cs, exp_cs(2, 0, 1), "auto CS after exchange");
        rd(A_XFR, v); check("R4", v[31], 0, "busy self-cleared");

        // R5 directed: short transmit count and underflow
        xg_setup(1, 1, 2'd1, 5, 3, 2);
        xg_start();
        xg_finish("R5", 5, 3, 2);

        // Random exchanges over all modes (R2 R3 R5)
        for (int t = 0; t < 14; t++) begin
            int nb, xm, nl;
            nb = 1 + int'($urandom % 16);
            xm = ($urandom % 3 == 0) ? int'($urandom % (nb + 1)) : nb;
            nl = ($urandom % 4 == 0) ? int'($urandom % (xm + 1)) : xm;
            xg_setup(1'($urandom), 1'($urandom), 2'($urandom), nb, xm, nl);
            xg_start();
            xg_finish("R3", nb, xm, nl);
        end

        // R12 zero burst
        xg_setup(0, 0, 0, 0, 0, 0);
        xg_start();
        repeat (60) @(negedge clk);
        check("R12", ecnt - base, 0, "SCK edges for zero burst");
        rd(A_XFR, v); check("R12", v[31], 0, "busy for zero burst");

        // R7 manual chip select
        wr(A_XFR, mk_xfr(0, 0, 0, 1, 2'd1, 1, 0));
        @(negedge clk); check("R7", spi_cs, 4'b1101, "manual level 0 active-low");
        wr(A_XFR, mk_xfr(0, 0, 0, 1, 2'd1, 1, 1));
        @(negedge clk); check("R7", spi_cs, 4'b1111, "manual level 1 active-low");
        wr(A_XFR, mk_xfr(0, 0, 0, 0, 2'd3, 1, 0));
        @(negedge clk); check("R7", spi_cs, 4'b1000, "manual level 0 active-high");

        // R8 RX FIFO reset
        xg_setup(0, 0, 0, 3, 3, 3);
        xg_start();
        wait_idle();
        rd(A_FST, v); check("R8", v, 3, "RX count before reset");
        wr(A_FCT, 32'h0000_8000);
        @(negedge clk);
        rd(A_FST, v); check("R8", v, 0, "RX count after reset");
        rd(A_FCT, v); check("R8", v, 0, "FIFO ctl self-clear");

        // R8 TX FIFO reset: stale bytes must not be sent
        wr(A_TXD, 32'hAB); wr(A_TXD, 32'hCD);
        wr(A_FCT, 32'h8000_0000);
        xg_setup(0, 0, 0, 2, 2, 0);
        xg_start();
        wait_idle();
        check("R8", mo[0], 8'h00, "MOSI after TX reset byte0");
        check("R8", mo[1], 8'h00, "MOSI after TX reset byte1");
        wr(A_FCT, 32'h0000_8000);

        // R11 pause in mid-byte
        xg_setup(0, 1, 0, 2, 2, 2);
        xg_start();
        repeat (20) @(negedge clk);
        wr(A_GLB, 32'h81);
        e1 = ecnt;
        repeat (60) @(negedge clk);
        check("R11", ecnt, e1, "SCK edges while paused");
        rd(A_XFR, v); check("R11", v[31], 1, "busy held while paused");
        wr(A_GLB, 32'h1);
        xg_finish("R11", 2, 2, 2);

        // R9 soft reset aborts
        xg_setup(1, 1, 0, 4, 4, 4);
        xg_start();
        repeat (40) @(negedge clk);
        wr(A_GLB, 32'h8000_0001);
        repeat (2) @(negedge clk);
        rd(A_XFR, v); check("R9", v[31], 0, "busy after soft reset");
        rd(A_FST, v); check("R9", v, 0, "RX count after soft reset");
        check("R9", spi_sck, 1, "SCK idle after soft reset");
        rd(A_GLB, v); check("R9", v[31], 0, "soft reset self-clear");

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule